// File: doc/BRIEF.md
# Peripheral Write-Protection Controller

This block sits next to a peripheral bus bridge and decides, for each of up to 32 peripherals behind that bridge, whether write transfers may reach it. It holds a vector of protection bits with one bit per peripheral. Software changes that vector through two register aliases, one that only sets bits and one that only clears bits. A mask can therefore be applied without a read-modify-write sequence, and reading either alias returns the live vector.

Every transfer the bridge forwards passes through a gate. The gate raises the select line of the addressed peripheral unless the transfer is a write to a protected peripheral, in which case no select is raised and an error pulse answers the transfer. As a guard on program flow, setting a bit that is already set, or clearing one that is already clear, is answered with an error on the register port. The valid part of that write still takes effect. Transfers tagged as debugger traffic skip every protection and flow check.

Top module: `perwr_guard`

## Requirements
- R1: While reset is asserted, `cfg_err`, `acc_err` and `cfg_rdata` are 0. After reset the protection vector equals parameter `RST_VAL`, which is all zeros by default.
- R2: A register write to address `SET_ADDR` sets every protection bit whose `cfg_wdata` bit is 1 and leaves the other bits unchanged, effective from the next cycle.
- R3: A register write to address `CLR_ADDR` clears every protection bit whose `cfg_wdata` bit is 1 and leaves the other bits unchanged, effective from the next cycle.
- R4: A register read of `SET_ADDR` or `CLR_ADDR` returns the protection vector on `cfg_rdata` in the cycle after the request. In every other cycle `cfg_rdata` is 0.
- R5: An `acc_valid` write (`acc_wr`=1) to index n below `N`, with bit n set and `acc_dbg`=0, drives `per_sel` to all zeros in the request cycle, and `acc_err` is 1 in the following cycle.
- R6: An `acc_valid` read to index n below `N`, or a write to an unprotected n, drives `per_sel` to one-hot bit n in the same cycle, and `acc_err` stays 0. The gate uses the vector as it was before any register write in that same cycle.
- R7: A non-debug write to `SET_ADDR` with a 1 on a bit that is already set makes `cfg_err` 1 in the next cycle. The other bits written as 1 are still set.
- R8: A non-debug write to `CLR_ADDR` with a 1 on a bit that is already clear makes `cfg_err` 1 in the next cycle. The other bits written as 1 are still cleared.
- R9: With `acc_dbg`=1 a write to a protected peripheral is selected and raises no error. With `cfg_dbg`=1 a redundant set or clear updates the vector and raises no error.
- R10: An access index of `N` or higher selects nothing and raises no error. A register write to any other address leaves the vector unchanged and raises no error.
- R11: Each faulting transfer raises its error output for exactly one cycle. When a single fault is followed by an idle cycle, the error is 0 again two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel | input | 1 | Register port request strobe |
| cfg_wr | input | 1 | Register port write (1) or read (0) |
| cfg_addr | input | ADDR_W | Register port address |
| cfg_wdata | input | N | Register port write data, one bit per peripheral |
| cfg_dbg | input | 1 | Register request comes from the debugger |
| cfg_rdata | output | N | Read data, valid the cycle after a read |
| cfg_err | output | 1 | Register port error pulse (set/clear flow fault) |
| acc_valid | input | 1 | Bridge transfer request |
| acc_wr | input | 1 | Bridge transfer is a write |
| acc_idx | input | IDX_W | Target peripheral index |
| acc_dbg | input | 1 | Bridge transfer comes from the debugger |
| per_sel | output | N | One-hot peripheral select, same cycle |
| acc_err | output | 1 | Bridge transfer error pulse, cycle after request |

## Verification
The hardest situation to reach from the ports is a redundant set or clear whose write data also contains valid bits. The bench has to show both the error and the partial update. This needs a vector that is already partly populated and a wide write mask that overlaps it only in part. Random stimulus alone reaches this only rarely. A directed sequence therefore first loads a known pattern, then issues an overlapping set and an overlapping clear, and reads the vector back. Random cycles then mix register writes, debugger tags, out-of-range indices and same-cycle register/bridge collisions against a bench model of the vector.

// File: rtl/perwr_guard_pkg.sv
package perwr_guard_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_READ = 2'd3
   } cfg_op_e;
endpackage

// File: rtl/perwr_decode.sv
module perwr_decode
   import perwr_guard_pkg::*;
#(
   parameter int          ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] SET_ADDR = 3,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 2
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output cfg_op_e           op
);
   logic hit_set, hit_clr;
   assign hit_set = (addr == SET_ADDR);
   assign hit_clr = (addr == CLR_ADDR);

   always_comb begin
      op = OP_NONE;
      if (sel) begin
         if (!wr && (hit_set || hit_clr)) op = OP_READ;
         else if (wr && hit_set)          op = OP_SET;
         else if (wr && hit_clr)          op = OP_CLR;
      end
   end
endmodule

// File: rtl/perwr_prot_reg.sv
module perwr_prot_reg
   import perwr_guard_pkg::*;
#(
   parameter int           N       = 12,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cfg_op_e      op,
   input  logic [N-1:0] wdata,
   input  logic         dbg,
   output logic [N-1:0] prot,
   output logic         err_q,
   output logic [N-1:0] rdata_q
);
   logic [N-1:0] prot_nxt;
   logic         fault;

   always_comb begin
      prot_nxt = prot;
      fault    = 1'b0;
      unique case (op)
         OP_SET: begin
            prot_nxt = prot | wdata;
            fault    = |(prot & wdata);
         end
         OP_CLR: begin
            prot_nxt = prot & ~wdata;
            fault    = |(~prot & wdata);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot    <= RST_VAL;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         prot    <= prot_nxt;
         err_q   <= fault && !dbg;
         rdata_q <= (op == OP_READ) ? prot : '0;
      end
   end

   assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SET) |=> ((prot & $past(wdata)) == $past(wdata)));
   assert_clr_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLR) |=> ((prot & $past(wdata)) == '0));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE || op == OP_READ) |=> $stable(prot));
   assert_dbg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |=> !err_q);
endmodule

// File: rtl/perwr_gate.sv
module perwr_gate #(
   parameter int N     = 12,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     prot,
   input  logic             acc_valid,
   input  logic             acc_wr,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_dbg,
   output logic [N-1:0]     per_sel,
   output logic             acc_err_q
);
   logic [N-1:0] blocked;

   for (genvar n = 0; n < N; n++) begin : g_port
      logic hit;
      assign hit        = acc_valid && (acc_idx == IDX_W'(n));
      assign blocked[n] = hit && acc_wr && !acc_dbg && prot[n];
      assign per_sel[n] = hit && !blocked[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_err_q <= 1'b0;
      else        acc_err_q <= |blocked;
   end

   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(per_sel));
   assert_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_wr && !acc_dbg && ({1'b0, acc_idx} < (IDX_W+1)'(N))
       && ((prot >> acc_idx) & N'(1)) != '0) |-> (per_sel == '0));
   assert_err_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err_q |-> ($past(per_sel) == '0));
   assert_dbg_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_dbg && ({1'b0, acc_idx} < (IDX_W+1)'(N)))
      |-> ($countones(per_sel) == 1));
   assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, acc_idx} >= (IDX_W+1)'(N)) |-> (per_sel == '0));
endmodule

// File: rtl/perwr_guard.sv
module perwr_guard
   import perwr_guard_pkg::*;
#(
   parameter int                N        = 12,
   parameter int                ADDR_W   = 4,
   parameter logic [ADDR_W-1:0] SET_ADDR = 3,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 2,
   parameter logic [N-1:0]      RST_VAL  = '0,
   localparam int               IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sel,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [N-1:0]      cfg_wdata,
   input  logic              cfg_dbg,
   output logic [N-1:0]      cfg_rdata,
   output logic              cfg_err,
   input  logic              acc_valid,
   input  logic              acc_wr,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic              acc_dbg,
   output logic [N-1:0]      per_sel,
   output logic              acc_err
);
   if (N < 1 || N > 32) begin : g_bad_n
      $error("perwr_guard: N must be 1..32");
   end
   if (SET_ADDR == CLR_ADDR) begin : g_bad_addr
      $error("perwr_guard: set and clear aliases must differ");
   end

   cfg_op_e      op;
   logic [N-1:0] prot;

   perwr_decode #(
      .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
   ) u_dec (
      .sel(cfg_sel), .wr(cfg_wr), .addr(cfg_addr), .op(op)
   );

   perwr_prot_reg #(.N(N), .RST_VAL(RST_VAL)) u_reg (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(cfg_wdata), .dbg(cfg_dbg),
      .prot(prot), .err_q(cfg_err), .rdata_q(cfg_rdata)
   );

   perwr_gate #(.N(N), .IDX_W(IDX_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .prot(prot), .acc_valid(acc_valid),
      .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_dbg(acc_dbg),
      .per_sel(per_sel), .acc_err_q(acc_err)
   );

   assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sel) |=> !cfg_err);
   assert_rdata_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sel || cfg_wr) |=> (cfg_rdata == '0));
endmodule

// File: tb/perwr_guard_test.sv
module perwr_guard_test;
   localparam int N = 12;
   localparam int ADDR_W = 4;
   localparam logic [3:0] SA = 4'd3;
   localparam logic [3:0] CA = 4'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_sel = 0, cfg_wr = 0, cfg_dbg = 0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [N-1:0] cfg_wdata = '0;
   logic [N-1:0] cfg_rdata;
   logic cfg_err;
   logic acc_valid = 0, acc_wr = 0, acc_dbg = 0;
   logic [3:0] acc_idx = '0;
   logic [N-1:0] per_sel;
   logic acc_err;

   always #4 clk = ~clk;

   perwr_guard #(.N(N), .ADDR_W(ADDR_W), .SET_ADDR(SA), .CLR_ADDR(CA)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_dbg(cfg_dbg),
      .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .acc_valid(acc_valid),
      .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_dbg(acc_dbg),
      .per_sel(per_sel), .acc_err(acc_err)
   );

   int vectors = 0, fails = 0;
   bit done = 0;
   logic [N-1:0] prot_m = '0;
   logic [N-1:0] e_rdata = '0;
   logic e_cerr = 0, e_aerr = 0, last_cerr = 0;
   string t_rdata = "R4", t_cerr = "R7", t_aerr = "R6";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_sel(input logic av, aw, ad,
                                            input logic [3:0] ai, input logic [N-1:0] p);
      if (!av || ai >= 4'(N)) return '0;
      if (aw && !ad && p[ai]) return '0;
      return N'(1) << ai;
   endfunction

   task automatic cyc(input logic s, w, input logic [3:0] a, input logic [N-1:0] d,
                      input logic cd, input logic av, aw, input logic [3:0] ai,
                      input logic ad, input string tg);
      logic [N-1:0] es;
      logic raw;
      @(negedge clk);
      chk(cfg_rdata == e_rdata, t_rdata, "cfg_rdata", 32'(cfg_rdata), 32'(e_rdata));
      chk(cfg_err == e_cerr, t_cerr, "cfg_err", 32'(cfg_err), 32'(e_cerr));
      chk(acc_err == e_aerr, t_aerr, "acc_err", 32'(acc_err), 32'(e_aerr));
      cfg_sel = s; cfg_wr = w; cfg_addr = a; cfg_wdata = d; cfg_dbg = cd;
      acc_valid = av; acc_wr = aw; acc_idx = ai; acc_dbg = ad;
      #1;
      es = exp_sel(av, aw, ad, ai, prot_m);
      chk(per_sel == es,
          (!av || ai >= 4'(N)) ? "R10" : (aw && prot_m[ai]) ? (ad ? "R9" : "R5") : "R6",
          "per_sel", 32'(per_sel), 32'(es));
      // registered expectations for the next cycle
      e_aerr = av && aw && !ad && ai < 4'(N) && prot_m[ai];
      t_aerr = (av && aw && ai < 4'(N) && prot_m[ai]) ? (ad ? "R9" : "R5") : "R11";
      e_rdata = (s && !w && (a == SA || a == CA)) ? prot_m : '0;
      t_rdata = (tg != "") ? tg : "R4";
      raw = 0;
      if (s && w && a == SA) begin
         raw = |(prot_m & d);
         prot_m = prot_m | d;
         t_cerr = cd && raw ? "R9" : "R7";
      end else if (s && w && a == CA) begin
         raw = |(~prot_m & d);
         prot_m = prot_m & ~d;
         t_cerr = cd && raw ? "R9" : "R8";
      end else begin
         t_cerr = last_cerr ? "R11" : "R10";
      end
      e_cerr = raw && !cd;
      if (!e_cerr && last_cerr) t_cerr = "R11";
      if (tg != "") t_cerr = tg;
      last_cerr = e_cerr;
   endtask

   task automatic idle(input string tg);
      cyc(0, 0, 4'd0, '0, 0, 0, 0, 4'd0, 0, tg);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(cfg_err == 0 && acc_err == 0, "R1", "err in reset", 32'({cfg_err, acc_err}), 0);
      chk(cfg_rdata == '0, "R1", "rdata in reset", 32'(cfg_rdata), 0);
      rst_n = 1'b1;
      cyc(1, 0, SA, '0, 0, 0, 0, 0, 0, "R1");            // read reset vector
      cyc(1, 1, SA, 12'h0F0, 0, 0, 0, 0, 0, "R2");       // set
      cyc(1, 0, CA, '0, 0, 0, 0, 0, 0, "R2");            // readback via clear alias
      cyc(1, 1, CA, 12'h030, 0, 0, 0, 0, 0, "R3");       // clear
      cyc(1, 0, SA, '0, 0, 0, 0, 0, 0, "R3");
      cyc(1, 1, SA, 12'h141, 0, 0, 0, 0, 0, "");         // overlap on bit 6 -> R7
      cyc(1, 0, SA, '0, 0, 0, 0, 0, 0, "R7");            // bits 0,8 still set
      idle("");                                          // R11 low again
      cyc(1, 1, CA, 12'h00C, 0, 0, 0, 0, 0, "");         // bits 2,3 clear -> R8
      cyc(1, 1, CA, 12'h101, 0, 0, 0, 0, 0, "");         // valid clear
      cyc(1, 0, CA, '0, 0, 0, 0, 0, 0, "R8");
      cyc(1, 1, SA, 12'h040, 1, 0, 0, 0, 0, "");         // debugger redundant set
      cyc(1, 1, 4'd7, 12'hFFF, 0, 1, 1, 4'd6, 0, "");    // unmapped write + blocked
      cyc(1, 0, SA, '0, 0, 1, 1, 4'd6, 1, "R10");        // debugger write passes
      cyc(0, 0, 0, '0, 0, 1, 0, 4'd6, 0, "");            // read passes
      cyc(0, 0, 0, '0, 0, 1, 1, 4'd13, 0, "");           // out of range
      cyc(1, 1, CA, 12'h040, 0, 1, 1, 4'd6, 0, "");      // collision: old vector gates
      cyc(0, 0, 0, '0, 0, 1, 1, 4'd6, 0, "");
      idle("");
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] a;
         logic [N-1:0] d;
         a = ($urandom % 4 != 0) ? (($urandom % 2) ? SA : CA) : 4'($urandom);
         d = ($urandom % 3 == 0) ? N'(1) << ($urandom % N) : N'($urandom);
         cyc(1'($urandom % 3 == 0), 1'($urandom), a, d, 1'($urandom % 8 == 0),
             1'($urandom % 2), 1'($urandom), 4'($urandom), 1'($urandom % 8 == 0), "");
      end
      idle("");
      idle("");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule